// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block turns the system clock into the timing of an SPI serial clock. It reads an eight-bit divisor code from configuration and, while a word is being shifted, emits a single-cycle `tick` each time the serial clock should change level. It also drives the serial clock level itself, so the shift logic can use either the pulse or the level.

A build-time parameter selects one of two code formats. The legacy format holds a 4-bit half-divisor and gives only even ratios from 4 to 30. The extended format multiplies a 4-bit linear factor by a power of two. The 3-bit exponent of that power is split across the code byte. This reaches ratios up to 1920, including odd ones.

The shift logic raises `word_active` for the length of a word. While `word_active` is low, the prescaler takes a fresh copy of the divisor and parks the serial clock at the idle level. While `word_active` is high, it counts using the copy it already holds.

Top module: `spi_clk_prescaler`

## Requirements
- R1: Legacy format: the divisor is twice `cfg_div[3:0]` (code 0x10 plus half the divisor). Bits [7:4] of `cfg_div` have no effect on the rate.
- R2: Legacy format: a coded divisor below 4 (`cfg_div[3:0]` of 0 or 1) runs at a ratio of 4.
- R3: Extended format: the linear factor L is `cfg_div[3:0]`. The exponent E has bit 0 at `cfg_div[4]` and bits [2:1] at `cfg_div[7:6]`. The divisor is L·2^E, up to 15·128 = 1920.
- R4: Extended format: `cfg_div[5]` has no effect on the rate.
- R5: Extended format: with L = 0 the code is invalid. `div_ok` reads 0, no `tick` is issued, and `sclk` stays at the idle level for the whole word.
- R6: Extended format: a product of 1 runs at a ratio of 2.
- R7: For a divisor D, each serial clock period lasts D system cycles. The high level lasts ceil(D/2) cycles and the low level lasts floor(D/2) cycles. Every level change coincides with a one-cycle `tick`, so four periods produce exactly eight ticks.
- R8: While `word_active` is low, `sclk` equals `cpol` (1 = idle high) one cycle later and `tick` is low. The first level of a word is the idle level.
- R9: A change of `cfg_div` while `word_active` is high does not alter the running rate. The new code is used from the next word on.
- R10: During reset, `sclk`, `tick` and `div_ok` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_div | input | 8 | Divisor code in the selected format |
| cpol | input | 1 | Idle level of the serial clock |
| word_active | input | 1 | High while the shift logic moves a word |
| tick | output | 1 | One-cycle pulse at each serial clock level change |
| sclk | output | 1 | Serial clock level |
| div_ok | output | 1 | The held divisor code is valid |

## Verification
The bench measures the lengths of the first two full serial clock levels after each start of a word, for both idle levels. This exposes a swapped duty split on odd ratios (R7) or an off-by-one phase reload, either of which shows as a wrong run length or tick count.

It targets several decoding mistakes:
- the legacy floor (R2);
- the split exponent bit (R3), where wrongly placed exponent bits give a ratio off by a power of two;
- the unused bit 5 (R4), where a decoder that reads it doubles the ratio;
- the product of 1 (R6), which would stall or lose ticks.

Finally, the bench changes the code in the middle of a word and counts ticks (R9). A design that reloads at once would slow the tick rate mid-word.

// File: rtl/spi_presc_pkg.sv
// Shared constants and the format selector for the serial clock prescaler.
// Field positions are fixed by the code formats; widths derive from them.
package spi_presc_pkg;

    typedef enum logic {
        ENC_LEGACY   = 1'b0,
        ENC_EXTENDED = 1'b1
    } presc_enc_e;

    localparam int CFG_W       = 8;   // width of the divisor code
    localparam int LIN_W       = 4;   // linear factor / half-divisor width
    localparam int EXP_W       = 3;   // exponent width (extended format)
    localparam int EXP0_POS    = 4;   // code bit holding exponent bit 0
    localparam int EXPHI_POS   = 6;   // lowest code bit of exponent bits [2:1]
    localparam int DIV_W       = LIN_W + (1 << EXP_W) - 1;
    localparam int LEG_MIN_DIV = 4;   // legacy floor
    localparam int MIN_DIV     = 2;   // smallest ratio the phase counter runs

endpackage

// File: rtl/presc_decode.sv
// Divisor code decoder.
// Turns the configuration code into a ratio of system cycles per serial clock
// period, plus a validity flag. Purely combinational. The ENC parameter picks
// the format at build time; the result is never below MIN_DIV.
module presc_decode
    import spi_presc_pkg::*;
#(
    parameter presc_enc_e ENC     = ENC_LEGACY,
    parameter int         DIV_W_P = DIV_W
) (
    input  logic [CFG_W-1:0]   cfg,
    output logic [DIV_W_P-1:0] div,
    output logic               valid
);

    generate
        if (ENC == ENC_LEGACY) begin : g_legacy
            logic [DIV_W_P-1:0] raw;

            // Double the half-divisor and apply the legacy floor.
            always_comb begin
                raw   = DIV_W_P'(cfg[LIN_W-1:0]) << 1;
                div   = (raw < DIV_W_P'(LEG_MIN_DIV)) ? DIV_W_P'(LEG_MIN_DIV) : raw;
                valid = 1'b1;
            end
        end else begin : g_extended
            logic [LIN_W-1:0]   lin;
            logic [EXP_W-1:0]   ex;
            logic [DIV_W_P-1:0] raw;

            // Gather the split exponent, scale the linear factor, floor at MIN_DIV.
            always_comb begin
                lin   = cfg[LIN_W-1:0];
                ex    = {cfg[EXPHI_POS +: EXP_W-1], cfg[EXP0_POS]};
                raw   = DIV_W_P'(lin) << ex;
                div   = (raw < DIV_W_P'(MIN_DIV)) ? DIV_W_P'(MIN_DIV) : raw;
                valid = (lin != '0);
            end
        end
    endgenerate

endmodule

// File: rtl/presc_phase.sv
// Serial clock phase counter.
// Holds the divisor between words and counts down the length of the current
// serial clock level. When the count reaches zero it issues a tick and flips
// the level. The high level takes the extra cycle of an odd ratio.
// Assumes div_in >= 2, so every level lasts at least one cycle.
module presc_phase #(
    parameter int DIV_W_P = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               word_active,
    input  logic               cpol,
    input  logic [DIV_W_P-1:0] div_in,
    input  logic               valid_in,
    output logic               tick,
    output logic               sclk,
    output logic               div_ok
);

    logic [DIV_W_P-1:0] div_q;
    logic [DIV_W_P-1:0] cnt;

    function automatic logic [DIV_W_P-1:0] high_len(input logic [DIV_W_P-1:0] d);
        return (d >> 1) + DIV_W_P'(d[0]);
    endfunction

    function automatic logic [DIV_W_P-1:0] low_len(input logic [DIV_W_P-1:0] d);
        return d >> 1;
    endfunction

    // A level ends when its count is spent, inside a valid word only.
    assign tick = word_active & div_ok & (cnt == '0);

    // Take the divisor between words, run the level counter during a word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= DIV_W_P'(2);
            div_ok <= 1'b0;
            sclk   <= 1'b0;
            cnt    <= '0;
        end else if (!word_active) begin
            div_q  <= div_in;
            div_ok <= valid_in;
            sclk   <= cpol;
            cnt    <= (cpol ? high_len(div_in) : low_len(div_in)) - 1'b1;
        end else if (tick) begin
            sclk   <= ~sclk;
            cnt    <= (sclk ? low_len(div_q) : high_len(div_q)) - 1'b1;
        end else if (div_ok) begin
            cnt    <= cnt - 1'b1;
        end
    end

    // R8: between words the clock sits at the idle level.
    p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(word_active)) |-> (sclk == $past(cpol)));

    // R7: inside a word the level only changes on a tick.
    p_toggle_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(word_active) && (sclk != $past(sclk))) |-> $past(tick));

    // R7: the remaining level count never exceeds the longer half period.
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_active && div_ok) |-> (cnt < high_len(div_q)));

    // R5: an invalid code leaves the clock frozen during a word.
    p_invalid_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && word_active && $past(word_active) && !div_ok) |-> $stable(sclk));

    // R9: the held divisor does not move within a word.
    p_div_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && word_active && $past(word_active)) |-> $stable(div_q));

endmodule

// File: rtl/spi_clk_prescaler.sv
// Serial clock prescaler top.
// Decodes the divisor code in the format chosen by ENC and drives the
// serial clock level plus its per-edge tick. The code is sampled only while
// word_active is low.
module spi_clk_prescaler
    import spi_presc_pkg::*;
#(
    parameter presc_enc_e ENC     = ENC_LEGACY,
    parameter int         DIV_W_P = DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_div,
    input  logic             cpol,
    input  logic             word_active,
    output logic             tick,
    output logic             sclk,
    output logic             div_ok
);

    logic [DIV_W_P-1:0] dec_div;
    logic               dec_valid;

    presc_decode #(
        .ENC     (ENC),
        .DIV_W_P (DIV_W_P)
    ) i_decode (
        .cfg   (cfg_div),
        .div   (dec_div),
        .valid (dec_valid)
    );

    presc_phase #(
        .DIV_W_P (DIV_W_P)
    ) i_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_active (word_active),
        .cpol        (cpol),
        .div_in      (dec_div),
        .valid_in    (dec_valid),
        .tick        (tick),
        .sclk        (sclk),
        .div_ok      (div_ok)
    );

    // R10: reset leaves the clock low with no tick.
    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(!rst_n) |-> (!sclk && !div_ok));

endmodule

// File: tb/test_spi_clk_prescaler.sv
`timescale 1ns/1ps
module test_spi_clk_prescaler;
    import spi_presc_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_div = 8'h00;
    logic       cpol = 1'b0;
    logic       word_active = 1'b0;
    logic       tick_l, sclk_l, ok_l;
    logic       tick_x, sclk_x, ok_x;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_clk_prescaler #(.ENC(ENC_LEGACY)) i_spi_clk_prescaler (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cpol(cpol),
        .word_active(word_active), .tick(tick_l), .sclk(sclk_l), .div_ok(ok_l));

    spi_clk_prescaler #(.ENC(ENC_EXTENDED)) i_spi_clk_prescaler_x (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cpol(cpol),
        .word_active(word_active), .tick(tick_x), .sclk(sclk_x), .div_ok(ok_x));

    typedef struct packed {
        logic        ext;
        logic [7:0]  cfg;
        logic        pol;
        logic [10:0] hi;
        logic [10:0] lo;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h12, 1'b0, 11'd2,   11'd2},    // R1 ratio 4
        '{1'b0, 8'h13, 1'b1, 11'd3,   11'd3},    // R1 ratio 6
        '{1'b0, 8'h1F, 1'b0, 11'd15,  11'd15},   // R1 ratio 30
        '{1'b0, 8'h10, 1'b0, 11'd2,   11'd2},    // R2 floor
        '{1'b0, 8'h11, 1'b1, 11'd2,   11'd2},    // R2 floor
        '{1'b0, 8'hE5, 1'b0, 11'd5,   11'd5},    // R1 upper bits ignored
        '{1'b1, 8'h03, 1'b0, 11'd2,   11'd1},    // R7 odd 3
        '{1'b1, 8'h05, 1'b1, 11'd3,   11'd2},    // R7 odd 5
        '{1'b1, 8'h13, 1'b0, 11'd3,   11'd3},    // R3 exp bit0
        '{1'b1, 8'h43, 1'b0, 11'd6,   11'd6},    // R3 exp bit1
        '{1'b1, 8'h83, 1'b1, 11'd24,  11'd24},   // R3 exp bit2
        '{1'b1, 8'hD3, 1'b0, 11'd192, 11'd192},  // R3 exp 7
        '{1'b1, 8'h33, 1'b0, 11'd3,   11'd3},    // R4 bit5 ignored
        '{1'b1, 8'h01, 1'b0, 11'd1,   11'd1},    // R6 product 1
        '{1'b1, 8'h02, 1'b1, 11'd1,   11'd1},    // R7 ratio 2
        '{1'b1, 8'hDF, 1'b0, 11'd960, 11'd960},  // R3 maximum
        '{1'b1, 8'h47, 1'b1, 11'd14,  11'd14},   // R3 ratio 28
        '{1'b1, 8'h09, 1'b1, 11'd5,   11'd4}     // R7 odd 9
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Start a word and record the first two level run lengths and the ticks.
    task automatic run_word(input bit ext, input logic [7:0] code, input bit pol,
                            input int nsamp, output int s0, output int okv,
                            output int r1, output int r2, output int nticks,
                            output int stuck);
        int level, len, nruns, s;
        @(negedge clk);
        word_active = 1'b0;
        cfg_div = code;
        cpol = pol;
        @(negedge clk);
        s0 = ext ? sclk_x : sclk_l;
        okv = ext ? ok_x : ok_l;
        word_active = 1'b1;
        level = s0; len = 1; nruns = 0; r1 = 0; r2 = 0; nticks = 0; stuck = 1;
        for (int i = 1; i <= nsamp; i++) begin
            @(negedge clk);
            s = ext ? sclk_x : sclk_l;
            nticks += ext ? int'(tick_x) : int'(tick_l);
            if (s != s0) stuck = 0;
            if (s == level) len++;
            else begin
                if (nruns == 0) r1 = len;
                else if (nruns == 1) r2 = len;
                nruns++;
                level = s;
                len = 1;
            end
        end
    endtask

    initial begin
        int s0, okv, r1, r2, nt, stuck, d;
        vec_t v;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(sclk_l == 0 && sclk_x == 0, "R10 sclk in reset", sclk_l + sclk_x, 0);
        chk(tick_l == 0 && tick_x == 0, "R10 tick in reset", tick_l + tick_x, 0);
        chk(ok_l == 0 && ok_x == 0, "R10 div_ok in reset", ok_l + ok_x, 0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            v = VECS[k];
            d = int'(v.hi) + int'(v.lo);
            run_word(v.ext, v.cfg, v.pol, 4 * d, s0, okv, r1, r2, nt, stuck);
            chk(okv == 1, $sformatf("R1/R3 div_ok vec %0d", k), okv, 1);
            chk(s0 == int'(v.pol), $sformatf("R8 first level vec %0d", k), s0, v.pol);
            chk(r1 == int'(v.pol ? v.hi : v.lo), $sformatf("R7 first level length vec %0d", k),
                r1, v.pol ? v.hi : v.lo);
            chk(r2 == int'(v.pol ? v.lo : v.hi), $sformatf("R7 second level length vec %0d", k),
                r2, v.pol ? v.lo : v.hi);
            chk(nt == 8, $sformatf("R7 ticks in four periods vec %0d", k), nt, 8);
        end

        // R5: invalid extended code, both idle levels
        for (int p = 0; p < 2; p++) begin
            run_word(1'b1, 8'hE0, p[0], 40, s0, okv, r1, r2, nt, stuck);
            chk(okv == 0, "R5 div_ok low", okv, 0);
            chk(nt == 0, "R5 no ticks", nt, 0);
            chk(stuck == 1 && s0 == p, "R5 sclk held idle", s0, p);
        end

        // R8: idle high between words, no tick
        @(negedge clk);
        word_active = 1'b0; cpol = 1'b1; cfg_div = 8'h12;
        @(negedge clk);
        chk(sclk_l == 1 && sclk_x == 1, "R8 idle high", sclk_l, 1);
        chk(tick_l == 0 && tick_x == 0, "R8 no tick idle", tick_l + tick_x, 0);

        // R9: mid-word code change keeps the running rate
        run_word(1'b1, 8'h02, 1'b0, 8, s0, okv, r1, r2, nt, stuck);
        cfg_div = 8'h0F;
        nt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            nt += int'(tick_x);
        end
        chk(nt == 20, "R9 rate unchanged mid-word", nt, 20);
        run_word(1'b1, 8'h0F, 1'b0, 60, s0, okv, r1, r2, nt, stuck);
        chk(r1 == 7 && r2 == 8, "R9 new code next word", r1 * 100 + r2, 708);

        @(negedge clk);
        word_active = 1'b0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule